// File: doc/BRIEF.md
# Duty-Cycle Clock Throttling Generator

This block slows a processor by gating its clock for part of every throttling frame. Software writes one control word. It holds a duty value in a parameterised field and an enable bit. While enabled with a non-zero duty value, the block drives an active-low stop-clock output, `stop_clk_n`. The output stays high, so the clock runs, for the first duty-value ticks of each frame. It goes low, so the clock stops, for the rest of the frame. A frame lasts 2^DUTY_W throttle ticks, so the clock runs for about duty / 2^DUTY_W of the time.

The intended way to change the duty value is to clear enable, write the new value while keeping the other bits, and then set enable again. This restarts the pattern at the start of a frame. If software rewrites the duty value while enable stays set, the new value is taken only at the next frame boundary, so a partial frame never appears. All bits of the control word, including those outside the two fields, read back exactly as written.

Top module: `clk_throttle_gen`

## Requirements
- R1: Reset behaviour. While `rst_n` is low and after its release, `stop_clk_n` is 1 and `rd_data` is zero.
- R2: Writing the control word. When `wr_en` is high at a clock edge, the whole `wr_data` word is stored. From the next cycle `rd_data` returns every bit of it unchanged. Without `wr_en`, `rd_data` holds its value.
- R3: Field positions. The duty value sits in bits [DUTY_LSB+DUTY_W-1:DUTY_LSB], which are [3:1] by default. The enable bit is bit EN_BIT, which is 4 by default. No other bit of the control word affects `stop_clk_n`.
- R4: Frame timing. One throttle tick lasts TICK_DIV clock cycles (4 by default). One frame lasts 2^DUTY_W ticks (8 by default).
- R5: Waveform. With enable set and duty value D not zero, `stop_clk_n` is 1 during ticks 0 to D-1 of each frame and 0 during ticks D to 2^DUTY_W-1. With D = 2^DUTY_W-1, the output is low for exactly one tick per frame.
- R6: Start point. After a write that sets enable with a non-zero duty value from the disabled state, tick 0 of the first frame begins at the next clock edge. The output is high in that tick.
- R7: Idle output. While enable is clear or the duty value is zero, `stop_clk_n` is 1. A write that clears enable forces the output high from the second edge after that write.
- R8: Restart. Enabling again after a disable starts the pattern at tick 0 of a fresh frame, whatever position the previous run had reached.
- R9: Duty change while enabled. If the duty value is rewritten while enable stays set, the current frame finishes with the old value. The new value applies from the first tick of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word to store |
| rd_data | output | REG_W | Stored control word |
| stop_clk_n | output | 1 | Stop-clock output, low stops the processor clock |

## Verification
A wrong frame position or tick count shows as a high-to-low transition at the wrong tick inside the very next frame. The pattern is compared every cycle, so such a fault is caught within one frame of 2^DUTY_W·TICK_DIV cycles. A stale or early-loaded active duty value shows in the first frame after a change made while running. A frame counter that is not cleared shows in the first tick after a re-enable, because a restart must begin with the output high. A control bit that is dropped or swapped appears at `rd_data` one cycle after the write.

// File: rtl/clk_throttle_pkg.sv
package clk_throttle_pkg;
  // Default geometry shared by the throttling generator and its helpers.
  localparam int unsigned DEF_REG_W    = 32;
  localparam int unsigned DEF_DUTY_LSB = 1;
  localparam int unsigned DEF_DUTY_W   = 3;
  localparam int unsigned DEF_EN_BIT   = 4;
  localparam int unsigned DEF_TICK_DIV = 4;
endpackage

// File: rtl/throttle_ctrl_reg.sv
module throttle_ctrl_reg #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/throttle_tick_gen.sv
module throttle_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick = cnt_en;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      assign tick = cnt_en && (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!cnt_en)   cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/throttle_frame_gen.sv
module throttle_frame_gen #(
  parameter int unsigned DUTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic              tick,
  output logic              stop_n,
  output logic              run_o,
  output logic [DUTY_W-1:0] pos_o,
  output logic [DUTY_W-1:0] act_o,
  output logic              frame_end
);
  localparam logic [DUTY_W-1:0] POS_MAX = '1;

  logic              run_q, run_d;
  logic [DUTY_W-1:0] pos_q, pos_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              stop_q, stop_d;

  assign frame_end = run_q && tick && (pos_q == POS_MAX);

  always_comb begin
    run_d  = run_q;
    pos_d  = pos_q;
    act_d  = act_q;
    stop_d = stop_q;
    if (!run_en) begin
      run_d  = 1'b0;
      pos_d  = '0;
      act_d  = '0;
      stop_d = 1'b1;
    end else if (!run_q) begin
      run_d  = 1'b1;
      pos_d  = '0;
      act_d  = duty;
      stop_d = 1'b1;
    end else if (tick) begin
      pos_d = pos_q + 1'b1;
      if (frame_end) act_d = duty;
      stop_d = (pos_d < act_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      act_q  <= '0;
      stop_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      pos_q  <= pos_d;
      act_q  <= act_d;
      stop_q <= stop_d;
    end
  end

  assign stop_n = stop_q;
  assign run_o  = run_q;
  assign pos_o  = pos_q;
  assign act_o  = act_q;
endmodule

// File: rtl/clk_throttle_gen.sv
module clk_throttle_gen
  import clk_throttle_pkg::*;
#(
  parameter int unsigned REG_W    = DEF_REG_W,
  parameter int unsigned DUTY_LSB = DEF_DUTY_LSB,
  parameter int unsigned DUTY_W   = DEF_DUTY_W,
  parameter int unsigned EN_BIT   = DEF_EN_BIT,
  parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             stop_clk_n
);
  logic [REG_W-1:0]  ctl;
  logic [DUTY_W-1:0] duty_fld;
  logic              run_en;
  logic              cnt_en;
  logic              tick_w;
  logic              run_w;
  logic [DUTY_W-1:0] pos_w;
  logic [DUTY_W-1:0] act_w;
  logic              fend_w;

  throttle_ctrl_reg #(.REG_W(REG_W)) i_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctl_q(ctl)
  );

  assign duty_fld = ctl[DUTY_LSB +: DUTY_W];
  assign run_en   = ctl[EN_BIT] && (duty_fld != '0);
  assign cnt_en   = run_w && run_en;

  throttle_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick_w)
  );

  throttle_frame_gen #(.DUTY_W(DUTY_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .duty(duty_fld), .tick(tick_w),
    .stop_n(stop_clk_n), .run_o(run_w), .pos_o(pos_w), .act_o(act_w),
    .frame_end(fend_w)
  );

  assign rd_data = ctl;
endmodule

// File: rtl/clk_throttle_chk.sv
module clk_throttle_chk #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned DUTY_LSB = 1,
  parameter int unsigned DUTY_W   = 3,
  parameter int unsigned EN_BIT   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic              stop_clk_n,
  input logic              run_q,
  input logic [DUTY_W-1:0] pos_q,
  input logic [DUTY_W-1:0] act_q,
  input logic              tick,
  input logic              frame_end
);
  logic live;
  assign live = rd_data[EN_BIT] && (rd_data[DUTY_LSB +: DUTY_W] != '0);

  // R2: a write is visible in full on the next cycle
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  // R2: the word holds without a write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R7: disabled or zero duty releases the clock
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> stop_clk_n);

  // R6: every run begins with the clock running
  a_r6_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> stop_clk_n);

  // R9: active duty moves only at a frame boundary while running
  a_r9_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && live && !frame_end) |=> $stable(act_q));

  // R4: the frame position advances only on a tick
  a_r4_pos_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && live && !tick) |=> $stable(pos_q));
endmodule

bind clk_throttle_gen clk_throttle_chk #(
  .REG_W(REG_W), .DUTY_LSB(DUTY_LSB), .DUTY_W(DUTY_W), .EN_BIT(EN_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .stop_clk_n(stop_clk_n), .run_q(run_w),
  .pos_q(pos_w), .act_q(act_w), .tick(tick_w), .frame_end(fend_w)
);

// File: tb/test_clk_throttle_gen.sv
module test_clk_throttle_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV  = 4;
  localparam int FRAME = 8;
  localparam int WDOG  = 20000;

  // table entry: {other bits, enable, duty}
  localparam logic [35:0] VEC [6] = '{
    {32'hDEAD_BEE0, 1'b1, 3'd1},
    {32'h0F0F_0F01, 1'b1, 3'd4},
    {32'hFFFF_FFE1, 1'b1, 3'd7},
    {32'h1234_5600, 1'b0, 3'd5},
    {32'h8000_0001, 1'b1, 3'd0},
    {32'h7FFF_FF00, 1'b1, 3'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        stop_clk_n;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_throttle_gen i_clk_throttle_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stop_clk_n(stop_clk_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(logic [31:0] o, logic e, logic [2:0] d);
    logic [31:0] w;
    w = o & ~32'h0000_001E;
    w[4] = e;
    w[3:1] = d;
    return w;
  endfunction

  function automatic logic exp_stop(int d, int k);
    if (d == 0) return 1'b1;
    return ((k / TDIV) % FRAME) < d;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 stop in reset", {31'd0, stop_clk_n}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stop after reset", {31'd0, stop_clk_n}, 32'd1);
    chk("R1 word after reset", rd_data, 32'd0);

    // table walk: R2 R3 R4 R5 R7
    foreach (VEC[i]) begin
      logic [31:0] o;
      logic        e;
      logic [2:0]  d;
      int          de;
      o = VEC[i][35:4];
      e = VEC[i][3];
      d = VEC[i][2:0];
      wr(mk(o, 1'b0, d));
      chk("R2 readback disabled", rd_data, mk(o, 1'b0, d));
      wr(mk(o, e, d));
      chk("R2 R3 readback", rd_data, mk(o, e, d));
      de = e ? int'(d) : 0;
      for (int k = 0; k < 2 * FRAME * TDIV; k++) begin
        @(negedge clk);
        if (de == 0) chk("R7 idle output", {31'd0, stop_clk_n}, 32'd1);
        else chk("R3 R4 R5 waveform", {31'd0, stop_clk_n}, {31'd0, exp_stop(de, k)});
      end
    end

    // R7 and R8: disable mid-frame, then restart from frame start
    wr(mk(32'h0, 1'b0, 3'd3));
    wr(mk(32'h0, 1'b1, 3'd3));
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      chk("R6 R5 first frame", {31'd0, stop_clk_n}, {31'd0, exp_stop(3, k)});
    end
    wr(mk(32'h0, 1'b0, 3'd3));
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R7 disabled high", {31'd0, stop_clk_n}, 32'd1);
    end
    wr(mk(32'h0, 1'b1, 3'd3));
    for (int k = 0; k < FRAME * TDIV; k++) begin
      @(negedge clk);
      chk("R8 restart", {31'd0, stop_clk_n}, {31'd0, exp_stop(3, k)});
    end

    // R9: duty rewritten while enabled is taken at the frame boundary
    wr(mk(32'h0, 1'b0, 3'd2));
    wr(mk(32'h0, 1'b1, 3'd2));
    for (int k = 0; k < 3 * FRAME * TDIV; k++) begin
      @(negedge clk);
      chk("R9 duty change", {31'd0, stop_clk_n},
          {31'd0, exp_stop((k < FRAME * TDIV) ? 2 : 6, k)});
      if (k == 10) begin
        wr_en = 1'b1;
        wr_data = mk(32'h0, 1'b1, 3'd6);
      end else if (k == 11) begin
        wr_en = 1'b0;
      end
    end

    // R7: zero duty with enable set holds the clock running
    wr(mk(32'hFFFF_FFFF, 1'b1, 3'd0));
    for (int k = 0; k < FRAME * TDIV; k++) begin
      @(negedge clk);
      chk("R7 zero duty", {31'd0, stop_clk_n}, 32'd1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule